// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short shift register holding the outcomes of the most recently resolved branches. That history is joined with a few low-order bits of the branch address to choose one entry in a table of small saturating counters. Each address therefore owns 2^HIST_W separate counters, and the recent global behaviour selects which one applies. The upper half of the counter range means "taken".

The fetch side presents an address with `pred_valid_i` and gets a combinational answer on `pred_taken_o`. It also receives the history the lookup used on `pred_hist_o`, and it must keep that value with the branch. When the branch resolves, the back end returns the address, that saved history and the real outcome on the update port. The addressed counter moves one step toward the outcome, and the history register shifts the outcome in. With `HIST_W = 0` the table is a plain per-address counter table. With `CTR_W = 1` each entry records only the last outcome.

Top module: `corr_branch_pred`

## Requirements
- R1: While `rst` is high at a rising clock edge, every counter is set to zero (strongly not taken) and the history register is set to all zeros. After release, every lookup predicts not taken and `pred_hist_o` reads zero.
- R2: On each edge with `upd_valid_i` high, the history register shifts left by one. `upd_taken_i` enters at bit 0 (1 = taken) and the oldest bit, the MSB, is lost. `pred_hist_o` shows the register.
- R3: The table index is `{history, addr[ADDR_IDX_W+1:2]}`, with the history in the upper bits. Address bits 1:0 and all bits above ADDR_IDX_W+1 have no effect, so branches that differ only there share an entry and no conflict is flagged. The prediction port indexes with the current history register.
- R4: A taken update increments the addressed counter. A counter that already holds 2^CTR_W−1 keeps that value.
- R5: A not-taken update decrements the addressed counter. A counter that already holds 0 keeps that value.
- R6: `pred_taken_o` is 1 when the selected counter is at least 2^(CTR_W−1), which is its MSB. With CTR_W = 2, a counter at 3 needs two not-taken updates before the prediction flips.
- R7: The update port writes the entry selected by `upd_hist_i` and `upd_addr_i`. It does not use the current history register.
- R8: When a lookup and an update select the same entry in one cycle, the lookup returns the value from before the update. The new value is seen from the next cycle on.
- R9: While `upd_valid_i` is low, no counter and no history bit changes, whatever the other update inputs carry.
- R10: While `pred_valid_i` is low, `pred_taken_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pred_valid_i | input | 1 | Lookup strobe |
| pred_addr_i | input | ADDR_W | Fetch address of the branch to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | max(HIST_W,1) | History used by the lookup (zero when HIST_W = 0) |
| upd_valid_i | input | 1 | Resolved-branch strobe |
| upd_addr_i | input | ADDR_W | Address of the resolved branch |
| upd_hist_i | input | max(HIST_W,1) | History that was returned at lookup time |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest case to reach from the ports is an update whose supplied history differs from the live history register. Only such an update shows whether training follows the saved index. The prediction port can only read entries under the current history, so the stimulus must first steer the register to a chosen pattern and then train through a different one. It then has to steer the register back before the trained entry can be observed. The vector sequence interleaves updates from two address slots to walk the history through 01, 11, 10 and 00. This lets the same address be watched under separate histories, including saturation at both ends and the one-miss hysteresis.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  // width of the byte offset below the address index field
  localparam int BYTE_OFS_W = 2;

  function automatic int at_least_one(input int v);
    return (v > 0) ? v : 1;
  endfunction
endpackage

// File: rtl/cbp_ghr.sv
module cbp_ghr #(
  parameter int HW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          shift_bit,
  output logic [HW-1:0] hist
);
  logic [HW-1:0] hist_q;

  generate
    if (HW > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HW-2:0], shift_bit};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= shift_bit;
      end
    end
  endgenerate

  assign hist = hist_q;
endmodule

// File: rtl/cbp_index.sv
module cbp_index #(
  parameter int ADDR_W     = 32,
  parameter int HIST_W     = 2,
  parameter int ADDR_IDX_W = 4,
  parameter int HW         = cbp_pkg::at_least_one(HIST_W),
  parameter int IDX_W      = HIST_W + ADDR_IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HW-1:0]     hist,
  output logic [IDX_W-1:0]  idx
);
  localparam int LO = cbp_pkg::BYTE_OFS_W;
  localparam int HI = LO + ADDR_IDX_W - 1;

  logic [ADDR_IDX_W-1:0] slot;
  assign slot = addr[HI:LO];

  // bits outside the index field are deliberately dropped (aliasing)
  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[ADDR_W-1:HI+1], addr[LO-1:0]};

  generate
    if (HIST_W > 0) begin : g_hist
      assign idx = {hist[HIST_W-1:0], slot};
    end else begin : g_nohist
      logic unused_hist;
      assign unused_hist = ^hist;
      assign idx = slot;
    end
  endgenerate
endmodule

// File: rtl/cbp_counter_table.sv
module cbp_counter_table #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CMIN = '0;
  localparam logic [CTR_W-1:0] ONE  = CTR_W'(1);

  logic [CTR_W-1:0] ctr_mem [DEPTH];
  logic [CTR_W-1:0] cur_val;
  logic [CTR_W-1:0] nxt_val;

  assign cur_val = ctr_mem[wr_idx];

  always_comb begin
    if (wr_taken) nxt_val = (cur_val == CMAX) ? cur_val : cur_val + ONE;
    else          nxt_val = (cur_val == CMIN) ? cur_val : cur_val - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_mem[i] <= CMIN;
    end else if (wr_en) begin
      ctr_mem[wr_idx] <= nxt_val;
    end
  end

  // read sees the stored value, so a same-cycle write shows next cycle
  assign rd_ctr = ctr_mem[rd_idx];
endmodule

// File: rtl/corr_branch_pred.sv
module corr_branch_pred #(
  parameter int ADDR_W     = 32,
  parameter int HIST_W     = 2,
  parameter int CTR_W      = 2,
  parameter int ADDR_IDX_W = 4,
  localparam int HW        = cbp_pkg::at_least_one(HIST_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pred_valid_i,
  input  logic [ADDR_W-1:0] pred_addr_i,
  output logic              pred_taken_o,
  output logic [HW-1:0]     pred_hist_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [HW-1:0]     upd_hist_i,
  input  logic              upd_taken_i
);
  localparam int IDX_W = HIST_W + ADDR_IDX_W;

  logic [HW-1:0]    live_hist;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic [CTR_W-1:0] rd_ctr;

  generate
    if (HIST_W > 0) begin : g_ghr
      cbp_ghr #(.HW(HW)) u_ghr (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (upd_valid_i),
        .shift_bit (upd_taken_i),
        .hist      (live_hist)
      );
    end else begin : g_noghr
      assign live_hist = '0;
    end
  endgenerate

  cbp_index #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .ADDR_IDX_W(ADDR_IDX_W)) u_rd_index (
    .addr (pred_addr_i),
    .hist (live_hist),
    .idx  (rd_idx)
  );

  cbp_index #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .ADDR_IDX_W(ADDR_IDX_W)) u_wr_index (
    .addr (upd_addr_i),
    .hist (upd_hist_i),
    .idx  (wr_idx)
  );

  cbp_counter_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (rd_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_valid_i),
    .wr_idx   (wr_idx),
    .wr_taken (upd_taken_i)
  );

  assign pred_taken_o = pred_valid_i & rd_ctr[CTR_W-1];
  assign pred_hist_o  = live_hist;
endmodule

// File: rtl/cbp_checker.sv
module cbp_checker #(
  parameter int HIST_W = 2,
  parameter int HW     = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          pred_valid_i,
  input logic          pred_taken_o,
  input logic [HW-1:0] pred_hist_o,
  input logic          upd_valid_i,
  input logic          upd_taken_i
);
  // R10: an idle lookup never reports taken
  assert_idle_lookup_R10: assert property (@(posedge clk) disable iff (rst)
    !pred_valid_i |-> !pred_taken_o);

  // R1: the first cycle after reset release shows a cleared history
  assert_reset_hist_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pred_hist_o == '0));

  // R9: no update strobe, no history movement
  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(upd_valid_i)) |-> $stable(pred_hist_o));

  generate
    if (HIST_W > 0) begin : g_hist_chk
      // R2: the newest outcome lands in bit 0
      assert_hist_newest_R2: assert property (@(posedge clk) disable iff (rst)
        upd_valid_i |=> (pred_hist_o[0] == $past(upd_taken_i)));
    end
    if (HIST_W > 1) begin : g_shift_chk
      // R2: older bits move up one place
      assert_hist_shift_R2: assert property (@(posedge clk) disable iff (rst)
        upd_valid_i |=> (pred_hist_o[HW-1:1] == $past(pred_hist_o[HW-2:0])));
    end
  endgenerate
endmodule

bind corr_branch_pred cbp_checker #(.HIST_W(HIST_W), .HW(HW)) u_cbp_checker (
  .clk          (clk),
  .rst          (rst),
  .pred_valid_i (pred_valid_i),
  .pred_taken_o (pred_taken_o),
  .pred_hist_o  (pred_hist_o),
  .upd_valid_i  (upd_valid_i),
  .upd_taken_i  (upd_taken_i)
);

// File: tb/corr_branch_pred_test.sv
module corr_branch_pred_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // fields: upd slot[13:10] upd hist[9:8] taken[7] lookup slot[6:3] exp pred[2] exp hist[1:0]
  localparam logic [13:0] VEC [NVEC] = '{
    14'b0011_00_1_0011_0_01,  // R4 count up, R2 shift
    14'b0011_00_1_0011_0_11,
    14'b0011_11_1_0011_0_11,
    14'b0011_11_1_0011_1_11,  // R6 threshold reached
    14'b0011_11_1_0011_1_11,
    14'b0011_11_1_0011_1_11,  // R4 saturated at 3
    14'b0011_11_0_0011_0_10,
    14'b1001_10_1_0011_0_01,
    14'b1001_01_1_0011_1_11,  // R6 one miss keeps taken
    14'b0011_11_0_0011_0_10,
    14'b0011_11_0_0011_1_00,  // R3/R7 other history untouched
    14'b0011_11_0_0011_1_00,  // R5 floor at 0
    14'b0111_00_1_0011_0_01,
    14'b0011_00_0_0011_0_10   // R3 aliased address bits
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pred_valid_i = 1'b0;
  logic [31:0] pred_addr_i = '0;
  logic        pred_taken_o;
  logic [1:0]  pred_hist_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_addr_i = '0;
  logic [1:0]  upd_hist_i = '0;
  logic        upd_taken_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_branch_pred uut (
    .clk(clk), .rst(rst),
    .pred_valid_i(pred_valid_i), .pred_addr_i(pred_addr_i),
    .pred_taken_o(pred_taken_o), .pred_hist_o(pred_hist_o),
    .upd_valid_i(upd_valid_i), .upd_addr_i(upd_addr_i),
    .upd_hist_i(upd_hist_i), .upd_taken_i(upd_taken_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_addr(input logic [3:0] s);
    return {26'd0, s, 2'b00};
  endfunction

  task automatic do_update(input logic [3:0] s, input logic [1:0] h, input logic t);
    @(negedge clk);
    upd_valid_i = 1'b1;
    upd_addr_i  = 32'h5A5A_F003 | slot_addr(s);
    upd_hist_i  = h;
    upd_taken_i = t;
    @(posedge clk);
    #1 upd_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    pred_valid_i = 1'b1;
    @(negedge clk);
    chk("R1 hist", 32'(pred_hist_o), 32'd0);
    for (int s = 0; s < 16; s += 5) begin
      pred_addr_i = slot_addr(4'(s));
      #1 chk("R1 pred", 32'(pred_taken_o), 32'd0);
    end

    for (int k = 0; k < NVEC; k++) begin
      do_update(VEC[k][13:10], VEC[k][9:8], VEC[k][7]);
      pred_addr_i = slot_addr(VEC[k][6:3]);
      @(negedge clk);
      chk($sformatf("R2 hist vec%0d", k), 32'(pred_hist_o), 32'(VEC[k][1:0]));
      chk($sformatf("R6 pred vec%0d", k), 32'(pred_taken_o), 32'(VEC[k][2]));
    end

    // R9: strobe low, other update inputs busy
    @(negedge clk);
    upd_addr_i = slot_addr(4'd3); upd_hist_i = 2'b10; upd_taken_i = 1'b1;
    repeat (3) @(negedge clk);
    pred_addr_i = slot_addr(4'd3);
    #1 chk("R9 pred", 32'(pred_taken_o), 32'd0);
    chk("R9 hist", 32'(pred_hist_o), 32'b10);

    // R7: reach history 11; slot 3 under 11 was trained down only via supplied history
    do_update(4'd12, 2'b00, 1'b1);
    do_update(4'd12, 2'b00, 1'b1);
    @(negedge clk);
    chk("R7 hist", 32'(pred_hist_o), 32'b11);
    chk("R7 pred", 32'(pred_taken_o), 32'd0);

    // R8: same-entry read and write in one cycle
    do_update(4'd3, 2'b11, 1'b1);
    @(negedge clk);
    upd_valid_i = 1'b1; upd_addr_i = slot_addr(4'd3); upd_hist_i = 2'b11; upd_taken_i = 1'b1;
    #1 chk("R8 old value", 32'(pred_taken_o), 32'd0);
    @(posedge clk);
    #1 upd_valid_i = 1'b0;
    @(negedge clk);
    chk("R8 new value", 32'(pred_taken_o), 32'd1);

    // R10: idle lookup on a taken entry
    pred_valid_i = 1'b0;
    #1 chk("R10 idle", 32'(pred_taken_o), 32'd0);
    pred_valid_i = 1'b1;
    #1 chk("R10 active", 32'(pred_taken_o), 32'd1);

    // R1: reset in mid-run clears counters and history
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    do_update(4'd0, 2'b00, 1'b1);
    do_update(4'd0, 2'b00, 1'b1);
    pred_addr_i = slot_addr(4'd3);
    @(negedge clk);
    chk("R1 rerun hist", 32'(pred_hist_o), 32'b11);
    chk("R1 rerun pred", 32'(pred_taken_o), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule